// File: doc/BRIEF.md
# Serial Flash Command Acceptance Gate

This block sits behind the serial deserializer of a NOR flash model and decides what happens to each framed instruction. It receives the raw serial clock and chip-select pins, brings both into the system clock domain, and counts serial clock rising edges while chip select is low. When chip select returns high it looks at the instruction class supplied by the decoder, together with the busy level and cycle kind reported by the internal cycle timer. It then raises at most one single-cycle strobe: execute, reject, suspend or resume.

Instructions that modify the device are accepted only when the frame closes on a whole byte. A frame that ends part-way through a byte makes the gate reject them. While an internal cycle is running, most instructions are dropped without any strobe. Status polls still go through, and a suspend is honoured only when the running cycle is an ordinary program or erase. A suspended-state flag remembers that a cycle is paused until a resume is accepted.

Top module: `flash_cmd_gate`

## Requirements
- R1: While reset is asserted and right after it is released, all four strobes and `suspended_o` are low.
- R2: With `busy_i` low, a modify-class frame (class code 1) whose chip select rises after a nonzero multiple of eight serial clock rising edges gives exactly one `exec_o` pulse.
- R3: With `busy_i` low, a modify-class frame whose edge count is not a multiple of eight gives one `reject_o` pulse and no `exec_o`. A frame of any class with zero serial clock edges raises no strobe.
- R4: With `busy_i` high, frames of modify, array-read (code 2) and other classes (code 0 and any undefined code) raise no strobe.
- R5: A status-poll frame (code 3) gives one `exec_o` pulse whatever `busy_i`, the edge alignment or the suspended state, and it leaves `suspended_o` unchanged.
- R6: A suspend frame (code 4) with `busy_i` high, cycle kind program (0) or erase (1), and `suspended_o` low gives one `suspend_o` pulse and sets `suspended_o` in the same cycle.
- R7: A suspend frame raises no strobe and leaves `suspended_o` unchanged when the cycle kind is OTP program (2), bulk erase (3), status write (4) or nonvolatile configuration write (5), when `busy_i` is low, or when a cycle is already suspended.
- R8: A resume frame (code 5) while `suspended_o` is high gives one `resume_o` pulse and clears `suspended_o`. While `suspended_o` is low it raises no strobe.
- R9: The edge count restarts on every falling edge of chip select, so edges from an earlier frame never count toward a later one.
- R10: Every strobe lasts one system clock cycle, and no two strobes are high in the same cycle.
- R11: With `busy_i` low, array-read and other-class frames with a nonzero edge count give one `exec_o` pulse, aligned or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock pin, asynchronous to `clk` |
| cs_n_i | input | 1 | Active-low chip-select pin, asynchronous to `clk` |
| op_class_i | input | 4 | Decoded instruction class, held until the frame is judged |
| busy_i | input | 1 | Internal modify cycle in progress |
| cyc_kind_i | input | 3 | Kind of the running internal cycle |
| exec_o | output | 1 | Execute strobe |
| reject_o | output | 1 | Reject strobe |
| suspend_o | output | 1 | Suspend strobe to the cycle timer |
| resume_o | output | 1 | Resume strobe to the cycle timer |
| suspended_o | output | 1 | A program or erase cycle is paused |

## Verification
The pins pass through two synchronizer stages and one edge-detect register. A chip-select rise sampled at one rising edge of `clk` is therefore judged two edges later, and the strobe is visible during the cycle that follows that edge. Edge counts move with the same two-edge delay. The bench's reference model keeps a four-deep history of the sampled pin values and works out the expected outputs at each rising edge. It compares them with the design at every falling edge, so a strobe that arrives one cycle early, arrives one cycle late, or lasts too long is reported.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

  typedef enum logic [3:0] {
    CLS_OTHER   = 4'd0,
    CLS_MODIFY  = 4'd1,
    CLS_READ    = 4'd2,
    CLS_POLL    = 4'd3,
    CLS_SUSPEND = 4'd4,
    CLS_RESUME  = 4'd5
  } cls_e;

  typedef enum logic [2:0] {
    CYC_PROG  = 3'd0,
    CYC_ERASE = 3'd1,
    CYC_OTP   = 3'd2,
    CYC_BULK  = 3'd3,
    CYC_SRWR  = 3'd4,
    CYC_NVCR  = 3'd5
  } cyc_e;

  typedef struct packed {
    logic exec;
    logic reject;
    logic susp;
    logic resume;
  } strobe_t;

  // whole-byte frame: low three bits clear and at least one edge
  function automatic logic byte_aligned(input logic [31:0] n);
    return (n[2:0] == 3'd0) && (n != 32'd0);
  endfunction

  // only plain program and erase cycles may be paused
  function automatic logic may_suspend(input logic [2:0] k);
    return (k == CYC_PROG) || (k == CYC_ERASE);
  endfunction

  // classes that still get through while a cycle runs
  function automatic logic passes_busy(input logic [3:0] c);
    return (c == CLS_POLL) || (c == CLS_SUSPEND) || (c == CLS_RESUME);
  endfunction

endpackage

// File: rtl/fcg_sync.sv
module fcg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
      prev  <= RST_VAL;
    end else begin
      chain <= {chain[LAST-1:0], d};
      prev  <= chain[LAST];
    end
  end

  assign q    = chain[LAST];
  assign rise = chain[LAST] & ~prev;
  assign fall = ~chain[LAST] & prev;

endmodule

// File: rtl/fcg_bitcount.sv
module fcg_bitcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_low,
  input  logic             cs_fall,
  input  logic             sck_rise,
  output logic [CNT_W-1:0] cnt
);
  logic count_edge;
  assign count_edge = cs_low & sck_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (cs_fall)    cnt <= '0;
    else if (count_edge) cnt <= cnt + 1'b1;
  end

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (cnt == '0));

endmodule

// File: rtl/fcg_decide.sv
module fcg_decide
  import fcg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic [CNT_W-1:0] cnt,
  input  logic [3:0]       cls,
  input  logic             busy,
  input  logic [2:0]       kind,
  output logic             exec_o,
  output logic             reject_o,
  output logic             suspend_o,
  output logic             resume_o,
  output logic             suspended_o
);
  strobe_t nxt, st_q;
  logic    susp_q, susp_d;
  logic    has_bits, aligned, blocked;

  assign has_bits = (cnt != '0);
  assign aligned  = byte_aligned(32'(cnt));
  assign blocked  = busy && !passes_busy(cls);

  always_comb begin
    nxt    = '0;
    susp_d = susp_q;
    if (frame_end && has_bits && !blocked) begin
      case (cls)
        CLS_MODIFY: begin
          nxt.exec   = aligned;
          nxt.reject = !aligned;
        end
        CLS_SUSPEND: begin
          if (busy && may_suspend(kind) && !susp_q) begin
            nxt.susp = 1'b1;
            susp_d   = 1'b1;
          end
        end
        CLS_RESUME: begin
          if (susp_q) begin
            nxt.resume = 1'b1;
            susp_d     = 1'b0;
          end
        end
        default: nxt.exec = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      susp_q <= 1'b0;
    end else begin
      st_q   <= nxt;
      susp_q <= susp_d;
    end
  end

  assign exec_o      = st_q.exec;
  assign reject_o    = st_q.reject;
  assign suspend_o   = st_q.susp;
  assign resume_o    = st_q.resume;
  assign suspended_o = susp_q;

  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exec_o, reject_o, suspend_o, resume_o}));

  // R10
  exec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_o |=> !exec_o);

  // R3
  misaligned_no_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && cls == CLS_MODIFY && !busy && cnt[2:0] != 3'd0)
      |=> (reject_o && !exec_o));

  // R4
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && busy && (cls == CLS_MODIFY || cls == CLS_READ))
      |=> !(exec_o || reject_o));

  // R6
  suspend_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_o |-> suspended_o);

  // R7
  suspend_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_o |-> ($past(busy) && ($past(kind) == CYC_PROG || $past(kind) == CYC_ERASE)));

  // R8
  resume_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |-> (!suspended_o && $past(suspended_o)));

endmodule

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_i,
  input  logic       cs_n_i,
  input  logic [3:0] op_class_i,
  input  logic       busy_i,
  input  logic [2:0] cyc_kind_i,
  output logic       exec_o,
  output logic       reject_o,
  output logic       suspend_o,
  output logic       resume_o,
  output logic       suspended_o
);
  localparam int LANES = 2;  // lane 0: chip select, lane 1: serial clock

  logic [LANES-1:0] pin_raw, pin_q, pin_rise, pin_fall;
  assign pin_raw = {sck_i, cs_n_i};

  for (genvar g = 0; g < LANES; g++) begin : g_sync
    fcg_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (logic'(g == 0))
    ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_raw[g]),
      .q    (pin_q[g]),
      .rise (pin_rise[g]),
      .fall (pin_fall[g])
    );
  end

  logic             cs_low, cs_fall, frame_end, sck_rise;
  logic [CNT_W-1:0] edge_cnt;

  assign cs_low    = ~pin_q[0];
  assign cs_fall   = pin_fall[0];
  assign frame_end = pin_rise[0];
  assign sck_rise  = pin_rise[1];

  fcg_bitcount #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_low  (cs_low),
    .cs_fall (cs_fall),
    .sck_rise(sck_rise),
    .cnt     (edge_cnt)
  );

  fcg_decide #(.CNT_W(CNT_W)) u_decide (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_end  (frame_end),
    .cnt        (edge_cnt),
    .cls        (op_class_i),
    .busy       (busy_i),
    .kind       (cyc_kind_i),
    .exec_o     (exec_o),
    .reject_o   (reject_o),
    .suspend_o  (suspend_o),
    .resume_o   (resume_o),
    .suspended_o(suspended_o)
  );

endmodule

// File: tb/flash_cmd_gate_test.sv
module flash_cmd_gate_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0;
  logic       cs_n = 1'b1;
  logic [3:0] cls = 4'd0;
  logic       busy = 1'b0;
  logic [2:0] kind = 3'd0;
  logic       exec_o, reject_o, suspend_o, resume_o, suspended_o;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_gate uut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n),
    .op_class_i(cls), .busy_i(busy), .cyc_kind_i(kind),
    .exec_o(exec_o), .reject_o(reject_o), .suspend_o(suspend_o),
    .resume_o(resume_o), .suspended_o(suspended_o)
  );

  // reference model: pin history, edge counter, pause flag
  bit cs_hist[$];
  bit sk_hist[$];
  int m_cnt;
  bit m_paused;
  bit x_exec, x_rej, x_sus, x_res;

  always @(posedge clk) begin
    if (!rst_n) begin
      cs_hist = '{1'b1, 1'b1, 1'b1, 1'b1};
      sk_hist = '{1'b0, 1'b0, 1'b0, 1'b0};
      m_cnt = 0; m_paused = 0;
      x_exec = 0; x_rej = 0; x_sus = 0; x_res = 0;
    end else begin
      cs_hist.push_front(cs_n); void'(cs_hist.pop_back());
      sk_hist.push_front(sck);  void'(sk_hist.pop_back());
      x_exec = 0; x_rej = 0; x_sus = 0; x_res = 0;
      if (cs_hist[2] && !cs_hist[3] && m_cnt > 0) begin
        if (cls == 4'd3) x_exec = 1;
        else if (cls == 4'd4) begin
          if (busy && kind <= 3'd1 && !m_paused) begin x_sus = 1; m_paused = 1; end
        end else if (cls == 4'd5) begin
          if (m_paused) begin x_res = 1; m_paused = 0; end
        end else if (!busy) begin
          if (cls == 4'd1) begin
            if (m_cnt % 8 == 0) x_exec = 1; else x_rej = 1;
          end else x_exec = 1;
        end
      end
      if (!cs_hist[2] && cs_hist[3]) m_cnt = 0;
      else if (!cs_hist[2] && sk_hist[2] && !sk_hist[3]) m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if ({exec_o, reject_o, suspend_o, resume_o, suspended_o} !==
          {x_exec, x_rej, x_sus, x_res, m_paused}) begin
        failures++;
        $display("FAIL %s t=%0t actual exe/rej/sus/res/flag=%b expected=%b", cur_req, $time,
                 {exec_o, reject_o, suspend_o, resume_o, suspended_o},
                 {x_exec, x_rej, x_sus, x_res, m_paused});
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input string req, input logic [3:0] c, input int nbits,
                       input logic b, input logic [2:0] k);
    cur_req = req;
    @(negedge clk);
    cls = c; busy = b; kind = k;
    wait_clk(2);
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b1; wait_clk(3);
      sck = 1'b0; wait_clk(3);
    end
    wait_clk(3);
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  initial begin
    wait_clk(3);
    checks++;  // R1: outputs during reset
    if ({exec_o, reject_o, suspend_o, resume_o, suspended_o} !== 5'b0) begin
      failures++;
      $display("FAIL R1 actual=%b expected=00000",
               {exec_o, reject_o, suspend_o, resume_o, suspended_o});
    end
    rst_n = 1'b1;
    wait_clk(4);

    frame("R2", 4'd1, 8, 1'b0, 3'd0);
    frame("R2", 4'd1, 16, 1'b0, 3'd0);
    frame("R3", 4'd1, 7, 1'b0, 3'd0);
    frame("R3", 4'd1, 13, 1'b0, 3'd0);
    frame("R3", 4'd1, 0, 1'b0, 3'd0);
    frame("R9", 4'd1, 3, 1'b0, 3'd0);
    frame("R9", 4'd1, 8, 1'b0, 3'd0);
    frame("R11", 4'd2, 5, 1'b0, 3'd0);
    frame("R11", 4'd0, 12, 1'b0, 3'd0);
    frame("R11", 4'd9, 8, 1'b0, 3'd0);
    frame("R4", 4'd1, 8, 1'b1, 3'd0);
    frame("R4", 4'd2, 8, 1'b1, 3'd1);
    frame("R4", 4'd0, 8, 1'b1, 3'd0);
    frame("R5", 4'd3, 8, 1'b1, 3'd0);
    frame("R5", 4'd3, 9, 1'b0, 3'd0);
    frame("R7", 4'd4, 8, 1'b0, 3'd0);
    frame("R7", 4'd4, 8, 1'b1, 3'd2);
    frame("R7", 4'd4, 8, 1'b1, 3'd3);
    frame("R7", 4'd4, 8, 1'b1, 3'd4);
    frame("R7", 4'd4, 8, 1'b1, 3'd5);
    frame("R8", 4'd5, 8, 1'b0, 3'd0);
    frame("R6", 4'd4, 8, 1'b1, 3'd0);
    frame("R7", 4'd4, 8, 1'b1, 3'd1);
    frame("R5", 4'd3, 8, 1'b0, 3'd0);
    frame("R8", 4'd5, 8, 1'b0, 3'd0);
    frame("R8", 4'd5, 8, 1'b0, 3'd0);
    frame("R6", 4'd4, 11, 1'b1, 3'd1);
    frame("R10", 4'd5, 8, 1'b0, 3'd1);
    frame("R2", 4'd1, 24, 1'b0, 3'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule